// File: doc/BRIEF.md
# SPI Serial Clock Divider with Settle Flag

This block generates the serial clock for a quad SPI host from a faster base clock. A small control word holds a clock enable, an 8-bit divider and a read-only settle flag. While enabled, each half of the serial clock lasts as many base cycles as the divider says, so the output runs at the base frequency divided by twice the divider. A divider of zero counts as one.

Software changes the rate by writing a new divider and then polling the settle flag. The flag drops on any write that changes the divider field. The new value is taken up only when the clock returns to its idle level, so the output never shows a shortened pulse. The flag comes back after a fixed number of complete periods at the new rate. The idle level follows a polarity input. Clearing the enable stops the clock at once at that idle level, and a divider written while stopped is taken up on the next cycle.

Top module: `spi_sck_divider`

## Requirements
- R1: After reset the control word reads 0x0002 (enable 0, settle flag 1, divider 0) and the serial clock sits at the idle level.
- R2: Control word layout: bit 0 is the enable, bit 1 is the read-only settle flag, bits 15:8 are the divider. Bits 7:2 read as zero, and writes to bits 1 and 7:2 are ignored. Enable and divider read back as written.
- R3: While enabled and settled, every high and every low stretch of the serial clock lasts exactly eff base cycles, so one period is 2*eff, where eff is the stored divider.
- R4: A stored divider of 0 behaves as eff = 1.
- R5: A write whose divider field differs from the stored divider makes the settle flag read 0 in the cycle after the write.
- R6: While running, a new divider is applied only at the end of an active half, when the clock returns to idle. Every half-period seen across a rate change lasts either the old or the new eff.
- R7: After a divider change while running, the settle flag reads 1 in the same cycle that the clock completes its (1+SETTLE_PERIODS)-th return to idle after the write, and reads 0 before that. With the default SETTLE_PERIODS = 2 this is the third return.
- R8: A write that repeats the stored divider leaves the settle flag at 1.
- R9: When the enable is 0, the serial clock is at the idle level from the cycle after the write onward. A divider written while disabled is applied on the next cycle, so the settle flag reads 0 one cycle after the write and 1 the cycle after that.
- R10: The idle level equals the cpol input. The active half is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Control word read value, including the settle flag |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Generated serial clock |

## Verification
The bench aims at the rate change while the clock runs. It measures every half-period across the change. A design that swaps the divider mid-half would show a runt stretch that matches neither the old nor the new width. It also pins the exact cycle when the settle flag returns: an early flag would let software drive data at an unsettled rate, and a late one would stall polling. Further cases are divider zero (a design that underflows its terminal count would stall or run at 2*256), the disabled path (the flag must return in one cycle rather than wait for edges that never come) and inverted polarity, where a design that ignores cpol would idle at the wrong level.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
   // field positions of the control word; software decodes these
   localparam int EN_BIT     = 0;
   localparam int STABLE_BIT = 1;
   localparam int DIV_LSB    = 8;
endpackage

// File: rtl/sckdiv_ctrl.sv
module sckdiv_ctrl
   import sckdiv_pkg::*;
#(
   parameter int CTRL_W         = 16,
   parameter int DIV_W          = 8,
   parameter int SETTLE_PERIODS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              boundary,
   output logic [CTRL_W-1:0] rd_data,
   output logic              en_o,
   output logic [DIV_W-1:0]  div_act_o
);
   localparam int SET_W = (SETTLE_PERIODS < 2) ? 1 : $clog2(SETTLE_PERIODS);

   logic              en_q;
   logic [DIV_W-1:0]  div_req_q;
   logic [DIV_W-1:0]  div_act_q;
   logic              pend_q;
   logic              stable_q;
   logic [SET_W-1:0]  settle_q;
   logic [DIV_W-1:0]  div_new;
   logic [DIV_W-1:0]  eff_req;
   logic              div_chg;
   logic              unused_wr;

   assign div_new   = wr_data[DIV_LSB +: DIV_W];
   assign eff_req   = (div_req_q == '0) ? DIV_W'(1) : div_req_q;
   assign div_chg   = wr_en && (div_new != div_req_q);
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         div_req_q <= '0;
         div_act_q <= DIV_W'(1);
         pend_q    <= 1'b0;
         stable_q  <= 1'b1;
         settle_q  <= '0;
      end else begin
         if (!en_q && pend_q) begin
            div_act_q <= eff_req;
            pend_q    <= 1'b0;
            stable_q  <= 1'b1;
         end else if (en_q && boundary) begin
            if (pend_q) begin
               div_act_q <= eff_req;
               pend_q    <= 1'b0;
               settle_q  <= '0;
            end else if (!stable_q) begin
               if (settle_q == SET_W'(SETTLE_PERIODS - 1))
                  stable_q <= 1'b1;
               else
                  settle_q <= settle_q + SET_W'(1);
            end
         end
         if (wr_en) begin
            en_q <= wr_data[EN_BIT];
            if (div_chg) begin
               div_req_q <= div_new;
               pend_q    <= 1'b1;
               stable_q  <= 1'b0;
               settle_q  <= '0;
            end
         end
      end
   end

   always_comb begin
      rd_data                    = '0;
      rd_data[EN_BIT]            = en_q;
      rd_data[STABLE_BIT]        = stable_q;
      rd_data[DIV_LSB +: DIV_W]  = div_req_q;
   end

   assign en_o      = en_q;
   assign div_act_o = div_act_q;

   // R5
   stable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data[DIV_LSB +: DIV_W] != div_req_q)) |=> !stable_q);

   // R6
   apply_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_act_q) |-> $past(boundary || !en_q));

   // R7
   settle_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_q) |-> !pend_q);

   // R4
   nonzero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_act_q != '0);
endmodule

// File: rtl/sckdiv_timebase.sv
module sckdiv_timebase #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_act,
   output logic             phase_o,
   output logic             boundary_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             phase_q;
   logic             term;

   assign term       = (cnt_q == div_act - DIV_W'(1));
   assign boundary_o = en && term && phase_q;
   assign phase_o    = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!en) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (term) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + DIV_W'(1);
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < div_act);

   // R3
   toggle_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_q) |-> $past(!en || (cnt_q == div_act - DIV_W'(1))));

   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/sckdiv_outstage.sv
module sckdiv_outstage #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic phase,
   input  logic cpol,
   output logic sclk
);
   logic lvl;

   assign lvl = en ? (cpol ^ phase) : cpol;

   generate
      if (OUT_REG) begin : g_reg
         logic sclk_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sclk_q <= 1'b0;
            else        sclk_q <= lvl;
         end
         assign sclk = sclk_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign sclk = lvl;
      end
   endgenerate
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
   import sckdiv_pkg::*;
#(
   parameter int CTRL_W         = 16,
   parameter int DIV_W          = 8,
   parameter int SETTLE_PERIODS = 2,
   parameter bit OUT_REG        = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CTRL_W-1:0] cfg_wr_data,
   output logic [CTRL_W-1:0] cfg_rd_data,
   input  logic              cpol,
   output logic              sclk
);
   generate
      if (DIV_LSB + DIV_W > CTRL_W) begin : g_bad_width
         $error("divider field does not fit in the control word");
      end
      if (SETTLE_PERIODS < 1) begin : g_bad_settle
         $error("SETTLE_PERIODS must be at least 1");
      end
   endgenerate

   logic             en;
   logic [DIV_W-1:0] div_act;
   logic             phase;
   logic             boundary;

   sckdiv_ctrl #(
      .CTRL_W(CTRL_W), .DIV_W(DIV_W), .SETTLE_PERIODS(SETTLE_PERIODS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
      .boundary(boundary), .rd_data(cfg_rd_data), .en_o(en), .div_act_o(div_act)
   );

   sckdiv_timebase #(.DIV_W(DIV_W)) u_timebase (
      .clk(clk), .rst_n(rst_n), .en(en), .div_act(div_act),
      .phase_o(phase), .boundary_o(boundary)
   );

   sckdiv_outstage #(.OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .en(en), .phase(phase), .cpol(cpol), .sclk(sclk)
   );
endmodule

// File: tb/spi_sck_divider_bench.sv
`timescale 1ns/1ps
module spi_sck_divider_bench;
   localparam int S = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd;
   logic        cpol_r = 1'b0;
   logic        sclk;

   int nchk = 0;
   int nerr = 0;
   int act_eff = 1;
   int cur_req = 0;

   always #2.5 clk = ~clk;

   spi_sck_divider u_spi_sck_divider (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
      .cfg_rd_data(rd), .cpol(cpol_r), .sclk(sclk)
   );

   function automatic int eff(int d);
      return (d == 0) ? 1 : d;
   endfunction

   function automatic bit ph();
      return sclk ^ cpol_r;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(logic [15:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic measure(int nd);
      bit pv;
      int len;
      int guard;
      pv = ph();
      guard = 0;
      while (ph() == pv && guard < 2000) begin step(); guard++; end
      pv = ph();
      len = 1;
      for (int k = 0; k < 4; k++) begin
         guard = 0;
         step();
         while (ph() == pv && guard < 2000) begin len++; step(); guard++; end
         check(len == nd, "R3/R4 half-period", len, nd);
         pv = ph();
         len = 1;
      end
   endtask

   task automatic change_div(int d);
      int old, nd, falls, seglen, guard;
      bit pv, first, early;
      old = act_eff;
      nd  = eff(d);
      wr({d[7:0], 8'h01});
      check(rd[15:8] == d[7:0] && rd[0], "R2 readback", int'(rd[15:8]), d);
      if (d == cur_req) begin
         check(rd[1] == 1'b1, "R8 stable kept", int'(rd[1]), 1);
         return;
      end
      check(rd[1] == 1'b0, "R5 stable cleared", int'(rd[1]), 0);
      pv = ph(); first = 1'b1; seglen = 1; falls = 0; early = 1'b0; guard = 0;
      while (guard < 20000) begin
         step();
         guard++;
         if (ph() != pv) begin
            if (!first)
               check(seglen == old || seglen == nd, "R6 no runt", seglen, nd);
            first = 1'b0;
            seglen = 1;
            if (pv == 1'b1) falls++;
         end else begin
            seglen++;
         end
         pv = ph();
         if (falls < 1 + S) begin
            if (rd[1]) early = 1'b1;
         end else begin
            check(rd[1] == 1'b1, "R7 stable at settle point", int'(rd[1]), 1);
            break;
         end
      end
      check(!early, "R7 stable not early", int'(early), 0);
      check(guard < 20000, "R7 settle reached", guard, 0);
      cur_req = d;
      act_eff = nd;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      bit okl;
      int d;
      void'($urandom(32'd20250611));
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // R1
      check(rd == 16'h0002, "R1 reset word", int'(rd), 2);
      check(sclk == 1'b0, "R1 reset idle", int'(sclk), 0);

      change_div(3);
      measure(3);
      change_div(0);   // R4
      measure(1);
      change_div(0);   // R8 same divider
      measure(1);

      // R2: bit1 and bits 7:2 written as don't-care
      wr(16'h00FD);
      check(rd == 16'h0003, "R2 ignored bits", int'(rd), 3);

      for (int i = 0; i < 16; i++) begin
         d = $urandom_range(12, 0);
         change_div(d);
         measure(eff(d));
      end

      change_div(255);
      measure(255);
      change_div(2);

      // R9: disable and change divider while stopped
      wr(16'h0500);
      check(sclk == cpol_r, "R9 idle after disable", int'(sclk), int'(cpol_r));
      check(rd[1] == 1'b0, "R5 stable cleared while off", int'(rd[1]), 0);
      step();
      check(rd[1] == 1'b1, "R9 applied next cycle", int'(rd[1]), 1);
      okl = 1'b1;
      for (int k = 0; k < 20; k++) begin
         step();
         if (sclk != cpol_r) okl = 1'b0;
      end
      check(okl, "R9 stays idle", int'(okl), 1);
      cur_req = 5; act_eff = 5;

      // R10: inverted polarity
      cpol_r = 1'b1;
      step();
      check(sclk == 1'b1, "R10 idle high", int'(sclk), 1);
      wr(16'h0501);
      check(sclk == 1'b1, "R10 idle half first", int'(sclk), 1);
      check(rd[1] == 1'b1, "R8 stable kept on enable", int'(rd[1]), 1);
      measure(5);
      change_div(4);
      measure(4);
      change_div(1);
      measure(1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule